// File: doc/BRIEF.md
# Clock Output Channel Controller

One output channel of a clock distribution block, meant to be instantiated five times side by side with a channel index parameter. The channel takes the distribution clock and produces a divided clock with a 50% duty cycle. An 8-bit programmable divider feeds a fixed divide-by-two stage, so the total ratio is twice the programmed value. A bypass path instead passes the distribution clock straight through, which gives a ratio of one and keeps the input's duty cycle.

Three signals gate the output: the channel's own enable bit, a global enable bit held in a shared register outside the channel, and an external global-enable pin. The pin has a pull-up, so when it is left unconnected the register bits alone decide the output. Gating always closes and opens while the gated waveform is low, so the output never shows a shortened pulse. The channel drives two single-ended legs. Each leg has its own 2-bit state mode that gives the normal clock, the inverted clock, a constant low, or tristate. Tristate appears as a per-leg output-enable driven low. A 4-bit phase delay code is stored and presented at a port for the analog delay line, which lies outside this block.

Configuration is written through a parallel load strobe that updates every field of the channel at once.

Top module: `clkchan_ctrl`

## Requirements
- R1: With bypass off and a divide value N from 1 to 255, the output period is 2*N distribution clock cycles: N=1 gives 2, N=3 gives 6, N=255 gives 510.
- R2: With bypass off, the divided output is high for exactly N cycles and low for exactly N cycles.
- R3: A write with divide value 0 leaves the divide setting unchanged. The output period stays that of the previous value, while the other fields of the same write still load.
- R4: With bypass on, the output follows the distribution clock: same period and same high time.
- R5: After reset, a channel whose index equals the default-on index (2) is enabled with divide value 6, which is a total ratio of 12. Bypass is off, both leg modes are normal and the delay code is 0. Every other channel is disabled and holds its legs low.
- R6: The output toggles only while the channel enable bit, the global enable bit and the global-enable pin are all 1. If any of them is 0, a leg in normal or inverted mode settles low.
- R7: Leg state codes: 2'b00 drives the gated clock, 2'b01 its complement, 2'b10 a constant low with output-enable 1, and 2'b11 output-enable 0 with data low. Leg A and leg B are set independently.
- R8: The 4-bit delay code written to the channel is presented unchanged on the delay output.
- R9: A new divide value takes effect at the next toggle of the divided clock. The half period in progress when the write happens completes with the old value.
- R10: When the gate closes or opens, only whole pulses reach the output. A pulse that is high when the channel is disabled lasts its full N cycles, and the first pulse after re-enabling is also N cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_dist | input | 1 | Distribution clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load strobe for all configuration fields |
| wr_div | input | DIV_W | Divide value N (0 ignored) |
| wr_bypass | input | 1 | 1 selects the divider bypass |
| wr_chan_en | input | 1 | Channel enable bit |
| wr_mode_a | input | 2 | Leg A state code |
| wr_mode_b | input | 2 | Leg B state code |
| wr_dly | input | DLY_W | Phase delay code |
| glob_en | input | 1 | Global output enable register bit |
| goe_pin | input | 1 | External global enable pin (pulled high) |
| out_a | output | 1 | Leg A data |
| oe_a | output | 1 | Leg A output enable |
| out_b | output | 1 | Leg B data |
| oe_b | output | 1 | Leg B output enable |
| dly_code | output | DLY_W | Stored phase delay code |

## Verification
On every cycle the assertions check the following. Each half period of the divided clock lasts as many cycles as the divide value loaded at its start. A zero write never moves the divide setting. The gate register changes only while the divided clock is low. A closed gate keeps a normal-mode leg low, and tristate mode drops the output-enable. Only the bench's scenarios can show the results that span many cycles: measured periods and high times at several divide values and in bypass, the reset defaults of an on-by-default channel and an off channel, the three-way enable, the retiming of a divide change, and the full width of the last and first pulses around a disable.

// File: rtl/clkchan_ctrl.sv
module clkchan_ctrl #(
  parameter int DIV_W      = 8,
  parameter int DLY_W      = 4,
  parameter int CHAN_ID    = 0,
  parameter int ON_CHAN    = 2,
  parameter int RST_DIV    = 6
) (
  input  logic             clk_dist,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             wr_bypass,
  input  logic             wr_chan_en,
  input  logic [1:0]       wr_mode_a,
  input  logic [1:0]       wr_mode_b,
  input  logic [DLY_W-1:0] wr_dly,
  input  logic             glob_en,
  input  logic             goe_pin,
  output logic             out_a,
  output logic             oe_a,
  output logic             out_b,
  output logic             oe_b,
  output logic [DLY_W-1:0] dly_code
);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(RST_DIV);
  localparam logic             EN_RST  = (CHAN_ID == ON_CHAN);
  localparam logic [1:0] M_NORM = 2'b00, M_INV = 2'b01, M_LOW = 2'b10;

  logic [DIV_W-1:0] div_reg, div_act, cnt;
  logic             byp, en_ch, div_q;
  logic [1:0]       mode_a, mode_b;
  logic [DLY_W-1:0] dly_q;
  logic             gate_tp, gate_tn, gate_cp;

  always_ff @(posedge clk_dist or negedge rst_n) begin
    if (!rst_n) begin
      div_reg <= DIV_RST;
      byp     <= 1'b0;
      en_ch   <= EN_RST;
      mode_a  <= M_NORM;
      mode_b  <= M_NORM;
      dly_q   <= '0;
    end else if (wr_en) begin
      if (wr_div != '0) div_reg <= wr_div;
      byp    <= wr_bypass;
      en_ch  <= wr_chan_en;
      mode_a <= wr_mode_a;
      mode_b <= wr_mode_b;
      dly_q  <= wr_dly;
    end
  end

  wire want = en_ch & glob_en & goe_pin;
  wire tc   = (cnt == div_act - 1'b1);
  wire q_nx = byp ? 1'b0 : (tc ? ~div_q : div_q);

  always_ff @(posedge clk_dist or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_q   <= 1'b0;
      div_act <= DIV_RST;
    end else if (byp || tc) begin
      cnt     <= '0;
      div_q   <= q_nx;
      div_act <= div_reg;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_dist or negedge rst_n) begin
    if (!rst_n) begin
      gate_tp <= 1'b0;
      gate_cp <= 1'b0;
    end else begin
      if (!byp && !q_nx) gate_tp <= want;
      if (byp || q_nx)   gate_cp <= want;
    end
  end

  always_ff @(negedge clk_dist or negedge rst_n) begin
    if (!rst_n) gate_tn <= 1'b0;
    else        gate_tn <= want;
  end

  wire tg = byp ? (clk_dist & gate_tn)  : (div_q & gate_tp);
  wire cg = byp ? (~clk_dist & gate_cp) : (~div_q & gate_cp);

  always_comb begin
    case (mode_a)
      M_NORM:  out_a = tg;
      M_INV:   out_a = cg;
      default: out_a = 1'b0;
    endcase
    case (mode_b)
      M_NORM:  out_b = tg;
      M_INV:   out_b = cg;
      default: out_b = 1'b0;
    endcase
  end

  assign oe_a     = (mode_a != 2'b11);
  assign oe_b     = (mode_b != 2'b11);
  assign dly_code = dly_q;
endmodule

module clkchan_ctrl_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [DIV_W-1:0] wr_div,
  input logic [DIV_W-1:0] div_reg,
  input logic [DIV_W-1:0] div_act,
  input logic             div_q,
  input logic             byp,
  input logic             gate_tp,
  input logic [1:0]       mode_a,
  input logic [1:0]       mode_b,
  input logic             out_a,
  input logic             out_b,
  input logic             oe_b
);
  logic             q_d, armed, gate_d;
  logic [DIV_W:0]   len;
  logic [DIV_W-1:0] len_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_d <= 1'b0; armed <= 1'b0; len <= '0; len_exp <= '0; gate_d <= 1'b0;
    end else begin
      q_d    <= div_q;
      gate_d <= gate_tp;
      if (byp) begin
        armed <= 1'b0;
        len   <= '0;
      end else if (div_q != q_d) begin
        armed   <= 1'b1;
        len     <= 1;
        len_exp <= div_act;
      end else begin
        len <= len + 1'b1;
      end
    end
  end

  assert_half_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !byp && div_q != q_d) |-> (len == {1'b0, len_exp}));

  assert_zero_div_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_div == '0) |=> (div_reg == $past(div_reg)));

  assert_gate_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp && gate_tp != gate_d) |-> !div_q);

  assert_closed_gate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp && !gate_tp && mode_a == 2'b00) |-> !out_a);

  assert_tristate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == 2'b11) |-> (!oe_b && !out_b));
endmodule

bind clkchan_ctrl clkchan_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk_dist), .rst_n(rst_n), .wr_en(wr_en), .wr_div(wr_div),
  .div_reg(div_reg), .div_act(div_act), .div_q(div_q), .byp(byp),
  .gate_tp(gate_tp), .mode_a(mode_a), .mode_b(mode_b),
  .out_a(out_a), .out_b(out_b), .oe_b(oe_b)
);

// File: tb/clkchan_ctrl_tb.sv
`timescale 1ns/1ps
module clkchan_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_bypass = 0, wr_chan_en = 0, glob_en = 1, goe_pin = 1;
  logic [7:0] wr_div = 0;
  logic [1:0] wr_mode_a = 0, wr_mode_b = 0;
  logic [3:0] wr_dly = 0;
  logic a_out, a_oe, b_out, b_oe, z_a, z_aoe, z_b, z_boe;
  logic [3:0] dly, z_dly;
  int checks = 0, fails = 0, ea = 0, ez = 0;

  always #2.5 clk = ~clk;

  clkchan_ctrl #(.CHAN_ID(2)) u_dut (
    .clk_dist(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_div(wr_div),
    .wr_bypass(wr_bypass), .wr_chan_en(wr_chan_en), .wr_mode_a(wr_mode_a),
    .wr_mode_b(wr_mode_b), .wr_dly(wr_dly), .glob_en(glob_en), .goe_pin(goe_pin),
    .out_a(a_out), .oe_a(a_oe), .out_b(b_out), .oe_b(b_oe), .dly_code(dly));

  clkchan_ctrl #(.CHAN_ID(0)) u_ch0 (
    .clk_dist(clk), .rst_n(rst_n), .wr_en(1'b0), .wr_div(wr_div),
    .wr_bypass(wr_bypass), .wr_chan_en(wr_chan_en), .wr_mode_a(wr_mode_a),
    .wr_mode_b(wr_mode_b), .wr_dly(wr_dly), .glob_en(glob_en), .goe_pin(goe_pin),
    .out_a(z_a), .oe_a(z_aoe), .out_b(z_b), .oe_b(z_boe), .dly_code(z_dly));

  always @(posedge a_out) ea++;
  always @(posedge z_a) ez++;

  task automatic chk(input bit ok, input string tag, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input real act, input real exp);
    chk((act - exp < 0.01) && (exp - act < 0.01), tag, act, exp);
  endtask

  task automatic wr(input logic [7:0] d, input logic bp, input logic en,
                    input logic [1:0] ma, input logic [1:0] mb, input logic [3:0] dl);
    @(negedge clk);
    wr_div = d; wr_bypass = bp; wr_chan_en = en; wr_mode_a = ma; wr_mode_b = mb; wr_dly = dl;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic meas(output real per, output real hi);
    realtime t0, t1, t2;
    @(posedge a_out); t0 = $realtime;
    @(negedge a_out); t1 = $realtime;
    @(posedge a_out); t2 = $realtime;
    hi = t1 - t0; per = t2 - t0;
  endtask

  task automatic edges_in(input int cyc, output int n);
    int s;
    s = ea;
    repeat (cyc) @(negedge clk);
    n = ea - s;
  endtask

  task automatic t_reset;
    real p, h; int s;
    s = ez;
    meas(p, h); meas(p, h);
    chk_eq("R5 default channel period", p, 60.0);
    chk_eq("R5 default channel high", h, 30.0);
    chk_eq("R5 default delay code", real'(dly), 0.0);
    repeat (40) @(negedge clk);
    chk_eq("R5 off channel edges", real'(ez - s), 0.0);
    chk_eq("R5 off channel leg", real'(z_a), 0.0);
  endtask

  task automatic t_divide;
    real p, h;
    int vals[3] = '{1, 3, 255};
    foreach (vals[i]) begin
      wr(8'(vals[i]), 0, 1, 2'b00, 2'b00, 0);
      meas(p, h); meas(p, h);
      chk_eq($sformatf("R1 period N=%0d", vals[i]), p, 10.0 * vals[i]);
      chk_eq($sformatf("R2 high time N=%0d", vals[i]), h, 5.0 * vals[i]);
    end
  endtask

  task automatic t_zero;
    real p, h;
    wr(8'd4, 0, 1, 2'b00, 2'b00, 0);
    meas(p, h);
    wr(8'd0, 0, 1, 2'b00, 2'b00, 4'd7);
    meas(p, h); meas(p, h);
    chk_eq("R3 zero write keeps period", p, 40.0);
    chk_eq("R3 other fields still load", real'(dly), 7.0);
  endtask

  task automatic t_bypass;
    real p, h;
    wr(8'd4, 1, 1, 2'b00, 2'b00, 0);
    meas(p, h); meas(p, h);
    chk_eq("R4 bypass period", p, 5.0);
    chk_eq("R4 bypass high", h, 2.5);
  endtask

  task automatic t_enable;
    int n;
    wr(8'd2, 0, 1, 2'b00, 2'b01, 0);
    for (int k = 0; k < 3; k++) begin
      if (k == 0) wr(8'd2, 0, 0, 2'b00, 2'b01, 0);
      if (k == 1) glob_en = 1'b0;
      if (k == 2) goe_pin = 1'b0;
      repeat (8) @(negedge clk);
      edges_in(40, n);
      chk_eq($sformatf("R6 no edges with input %0d low", k), real'(n), 0.0);
      chk_eq($sformatf("R6 normal leg low with input %0d low", k), real'(a_out), 0.0);
      chk_eq($sformatf("R6 inverted leg low with input %0d low", k), real'(b_out), 0.0);
      if (k == 0) wr(8'd2, 0, 1, 2'b00, 2'b01, 0);
      if (k == 1) glob_en = 1'b1;
      if (k == 2) goe_pin = 1'b1;
      repeat (8) @(negedge clk);
      edges_in(40, n);
      chk_eq($sformatf("R6 edges return after input %0d", k), real'(n), 10.0);
    end
  endtask

  task automatic t_modes;
    int bad = 0;
    wr(8'd3, 0, 1, 2'b00, 2'b01, 0);
    repeat (12) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (b_out !== ~a_out || !b_oe || !a_oe) bad++;
    end
    chk_eq("R7 leg B inverted vs leg A", real'(bad), 0.0);
    wr(8'd3, 0, 1, 2'b00, 2'b10, 0);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (b_out !== 1'b0 || b_oe !== 1'b1) bad++;
    end
    chk_eq("R7 leg B held low, enabled", real'(bad), 0.0);
    wr(8'd3, 0, 1, 2'b11, 2'b00, 0);
    @(negedge clk);
    chk_eq("R7 leg A tristate oe", real'(a_oe), 0.0);
    chk_eq("R7 leg A tristate data", real'(a_out), 0.0);
    chk_eq("R7 leg B normal oe", real'(b_oe), 1.0);
  endtask

  task automatic t_dly;
    wr(8'd3, 0, 1, 2'b00, 2'b00, 4'd15);
    chk_eq("R8 delay code 15", real'(dly), 15.0);
    wr(8'd3, 0, 1, 2'b00, 2'b00, 4'd9);
    chk_eq("R8 delay code 9", real'(dly), 9.0);
  endtask

  task automatic t_retime;
    real p, h; realtime t0, t1, t2;
    wr(8'd8, 0, 1, 2'b00, 2'b00, 0);
    meas(p, h);
    @(posedge a_out); t0 = $realtime;
    repeat (2) @(negedge clk);
    wr(8'd2, 0, 1, 2'b00, 2'b00, 0);
    @(negedge a_out); t1 = $realtime;
    @(posedge a_out); t2 = $realtime;
    chk_eq("R9 half period in progress keeps old value", t1 - t0, 40.0);
    chk_eq("R9 next half period uses new value", t2 - t1, 10.0);
  endtask

  task automatic t_gating;
    real p, h; realtime t0, t1; int n;
    wr(8'd6, 0, 1, 2'b00, 2'b00, 0);
    meas(p, h);
    @(posedge a_out); t0 = $realtime;
    wr(8'd6, 0, 0, 2'b00, 2'b00, 0);
    @(negedge a_out); t1 = $realtime;
    chk_eq("R10 last pulse full width", t1 - t0, 30.0);
    edges_in(40, n);
    chk_eq("R10 silent after disable", real'(n), 0.0);
    wr(8'd6, 0, 1, 2'b00, 2'b00, 0);
    @(posedge a_out); t0 = $realtime;
    @(negedge a_out); t1 = $realtime;
    chk_eq("R10 first pulse full width", t1 - t0, 30.0);
  endtask

  initial begin
    #(5.0 * 190000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_divide();
    t_zero();
    t_bypass();
    t_enable();
    t_modes();
    t_dly();
    t_retime();
    t_gating();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule